// File: doc/BRIEF.md
# SpaceWire Character Decoder

This block sits between a data-strobe front end and a link controller. It takes the recovered line one bit at a time: a bit is present when `bit_vld` is high, and a separate `line_act` input shows line activity. From these bits it rebuilds SpaceWire characters and reports them to the controller. Flow-control tokens come out as single-cycle pulses. Data bytes and end-of-packet markers come out as single-cycle strobes with a flag and a byte. Time codes come out as a tick, and their value is held until the next time code. Three error flags report a quiet line, a parity error and a bad escape sequence.

Until the receiver has aligned to a NULL it has no character framing. In that phase it only looks for the NULL bit pattern in a sliding window and reports nothing else. The disconnect watch runs apart from the framing and starts at the first sign of activity. Pulling `rx_en` low returns every register to its idle value, so the controller restarts the receiver by disabling it and enabling it again.

Top module: `sw_char_rx`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: `got_bit` goes high on the clock edge that samples `line_act` high with `rx_en` high. It stays high until `rx_en` is low.
- R3: Before alignment, no character, pulse or error is produced. `got_null` goes high on the edge that samples the bit that completes the arrival-order sequence 1,1,1,0,1,0,0. This is the tail of an escape plus a flow-control token.
- R4: A flow-control token (control code 0) gives `fct_pulse` for exactly one cycle. When it follows an escape it forms a NULL, and no pulse is given.
- R5: Each character is a parity bit, then a flag bit (1 = control), then the payload. Control payloads are 2 bits, with code 0 = flow-control token, 1 = end of packet, 2 = error end of packet, 3 = escape. Data payloads are 8 bits. Both are sent least significant bit first. In the cycle after the final bit, `char_strobe` is high for one cycle. Data gives flag 0 with the byte. End of packet gives flag 1 with byte 0x00, and error end of packet gives flag 1 with byte 0x01. `char_flag` and `char_byte` are 0 whenever there is no strobe. At most one of `char_strobe`, `fct_pulse` and `tc_tick` is high in any cycle.
- R6: An escape followed by a data character gives a one-cycle `tc_tick`. It loads `tc_ctrl` with byte bits 7:6 and `tc_count` with bits 5:0. Both hold until the next time code.
- R7: Parity is odd over the payload bits of the previous character plus the parity and flag bits of the current character. A mismatch sets `err_par`. This can happen only while `got_null` is high, and the flag stays set until `rx_en` is low.
- R8: An escape followed by end of packet, error end of packet or another escape sets `err_esc`, which stays set until `rx_en` is low.
- R9: Once a parity or escape error is detected, no further strobe, pulse or tick is produced. This includes the offending character.
- R10: The first edge with `rx_en` low clears `got_bit`, `got_null`, all error flags and the time code value.
- R11: After `got_bit`, `err_disc` rises on the edge that completes `disc_limit` consecutive cycles without `line_act`. A limit of 0 acts as 1. The flag drops on the edge that samples `line_act` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; low clears all state |
| line_act | input | 1 | Activity seen on the line this cycle |
| bit_vld | input | 1 | `bit_in` carries a received bit |
| bit_in | input | 1 | Received bit |
| disc_limit | input | 8 | Idle cycles before a disconnect is reported |
| got_bit | output | 1 | Activity seen since enable |
| got_null | output | 1 | Aligned on a NULL since enable |
| fct_pulse | output | 1 | Flow-control token received |
| char_strobe | output | 1 | Data or packet-end character received |
| char_flag | output | 1 | 1 for packet end, 0 for data |
| char_byte | output | 8 | Data byte, or 0x00/0x01 for packet ends |
| tc_tick | output | 1 | Time code received |
| tc_ctrl | output | 2 | Control bits of the last time code |
| tc_count | output | 6 | Counter of the last time code |
| err_disc | output | 1 | Line idle for too long |
| err_par | output | 1 | Parity error, sticky |
| err_esc | output | 1 | Escape sequence error, sticky |

## Verification
The disconnect watch and the character path are separate logic. A time code can therefore complete on the same edge that the idle count reaches its limit. The bench provokes this with a disconnect limit of 3. It sends the final three bits of the time code's data character with `line_act` held low, so the last bit and the third idle cycle fall on one edge. It then requires `tc_tick`, the expected time code value and `err_disc` all to be high in the following cycle, with neither event hiding the other.

// File: rtl/sw_rx_pkg.sv
package sw_rx_pkg;

    localparam int DATA_W   = 8;
    localparam int CTL_W    = 2;
    localparam int SYNC_W   = 7;
    localparam int LIMIT_W  = 8;

    // arrival order, oldest bit in the MSB: flag,1,1 of escape then 0,1,0,0
    localparam logic [SYNC_W-1:0] SYNC_SEQ = 7'b1110100;

    typedef enum logic [CTL_W-1:0] {
        CC_FCT = 2'd0,
        CC_EOP = 2'd1,
        CC_EEP = 2'd2,
        CC_ESC = 2'd3
    } ctl_code_e;

endpackage

// File: rtl/sw_rx_disc.sv
module sw_rx_disc #(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             act,
    input  logic [LIM_W-1:0] limit,
    output logic             got_bit,
    output logic             err_disc
);

    typedef struct packed {
        logic             got;
        logic             err;
        logic [LIM_W-1:0] cnt;
    } disc_st_t;

    disc_st_t st_d, st_q;
    logic [LIM_W:0] next_idle;

    always_comb begin
        st_d      = st_q;
        next_idle = {1'b0, st_q.cnt} + {{LIM_W{1'b0}}, 1'b1};
        if (!en) begin
            st_d = '0;
        end else if (act) begin
            st_d.got = 1'b1;
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (st_q.got) begin
            if (st_q.cnt != {LIM_W{1'b1}}) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (next_idle >= {1'b0, limit}) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign got_bit  = st_q.got;
    assign err_disc = st_q.err;

endmodule

// File: rtl/sw_rx_framer.sv
module sw_rx_framer
    import sw_rx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CTL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_vld,
    input  logic          bit_in,
    output logic          synced,
    output logic          done,
    output logic          done_ctrl,
    output logic [DW-1:0] done_payload,
    output logic          par_err
);

    localparam int POS_W = $clog2(DW + 2);
    localparam int IDX_W = $clog2(DW);
    localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DW - 1);
    localparam logic [IDX_W-1:0] LAST_CTL  = IDX_W'(CW - 1);

    typedef struct packed {
        logic              synced;
        logic [SYNC_W-1:0] win;
        logic [POS_W-1:0]  pos;
        logic              par;
        logic              is_ctrl;
        logic              acc;
        logic [DW-1:0]     shreg;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [SYNC_W-1:0] win_nx;
    logic [POS_W-1:0]  offs;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;

    always_comb begin
        st_d     = st_q;
        done     = 1'b0;
        par_err  = 1'b0;
        win_nx   = {st_q.win[SYNC_W-2:0], bit_in};
        offs     = st_q.pos - POS_W'(2);
        idx      = offs[IDX_W-1:0];
        last_idx = st_q.is_ctrl ? LAST_CTL : LAST_DATA;
        if (!en) begin
            st_d = '0;
        end else if (bit_vld) begin
            if (!st_q.synced) begin
                st_d.win = win_nx;
                if (win_nx == SYNC_SEQ) begin
                    st_d.synced = 1'b1;
                    st_d.pos    = '0;
                    st_d.acc    = 1'b0;
                end
            end else if (st_q.pos == POS_W'(0)) begin
                st_d.par = bit_in;
                st_d.pos = POS_W'(1);
            end else if (st_q.pos == POS_W'(1)) begin
                par_err        = ~(st_q.acc ^ st_q.par ^ bit_in);
                st_d.is_ctrl   = bit_in;
                st_d.acc       = 1'b0;
                st_d.shreg     = '0;
                st_d.pos       = POS_W'(2);
            end else begin
                st_d.shreg[idx] = bit_in;
                st_d.acc        = st_q.acc ^ bit_in;
                if (idx == last_idx) begin
                    done     = 1'b1;
                    st_d.pos = '0;
                end else begin
                    st_d.pos = st_q.pos + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign synced       = st_q.synced;
    assign done_ctrl    = st_q.is_ctrl;
    assign done_payload = st_d.shreg;

endmodule

// File: rtl/sw_rx_decode.sv
module sw_rx_decode
    import sw_rx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          done,
    input  logic          done_ctrl,
    input  logic [DW-1:0] done_payload,
    input  logic          par_err,
    output logic          fct_pulse,
    output logic          char_strobe,
    output logic          char_flag,
    output logic [DW-1:0] char_byte,
    output logic          tc_tick,
    output logic [1:0]    tc_ctrl,
    output logic [DW-3:0] tc_count,
    output logic          err_par,
    output logic          err_esc
);

    typedef struct packed {
        logic          esc_pend;
        logic          fct;
        logic          strobe;
        logic          flag;
        logic [DW-1:0] byte_v;
        logic          tick;
        logic [1:0]    tctl;
        logic [DW-3:0] tcnt;
        logic          e_par;
        logic          e_esc;
    } dec_st_t;

    dec_st_t   st_d, st_q;
    logic      blocked;
    ctl_code_e code;

    always_comb begin
        st_d        = st_q;
        st_d.fct    = 1'b0;
        st_d.strobe = 1'b0;
        st_d.flag   = 1'b0;
        st_d.byte_v = '0;
        st_d.tick   = 1'b0;
        blocked     = st_q.e_par | st_q.e_esc | par_err;
        code        = ctl_code_e'(done_payload[CTL_W-1:0]);
        if (!en) begin
            st_d = '0;
        end else begin
            if (par_err) begin
                st_d.e_par = 1'b1;
            end
            if (done && !blocked) begin
                if (done_ctrl) begin
                    if (st_q.esc_pend) begin
                        st_d.esc_pend = 1'b0;
                        if (code != CC_FCT) begin
                            st_d.e_esc = 1'b1;
                        end
                    end else begin
                        case (code)
                            CC_FCT: st_d.fct = 1'b1;
                            CC_EOP: begin
                                st_d.strobe = 1'b1;
                                st_d.flag   = 1'b1;
                                st_d.byte_v = DW'(0);
                            end
                            CC_EEP: begin
                                st_d.strobe = 1'b1;
                                st_d.flag   = 1'b1;
                                st_d.byte_v = DW'(1);
                            end
                            default: st_d.esc_pend = 1'b1;
                        endcase
                    end
                end else if (st_q.esc_pend) begin
                    st_d.esc_pend = 1'b0;
                    st_d.tick     = 1'b1;
                    st_d.tctl     = done_payload[DW-1:DW-2];
                    st_d.tcnt     = done_payload[DW-3:0];
                end else begin
                    st_d.strobe = 1'b1;
                    st_d.byte_v = done_payload;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fct_pulse   = st_q.fct;
    assign char_strobe = st_q.strobe;
    assign char_flag   = st_q.flag;
    assign char_byte   = st_q.byte_v;
    assign tc_tick     = st_q.tick;
    assign tc_ctrl     = st_q.tctl;
    assign tc_count    = st_q.tcnt;
    assign err_par     = st_q.e_par;
    assign err_esc     = st_q.e_esc;

endmodule

// File: rtl/sw_char_rx.sv
module sw_char_rx
    import sw_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               line_act,
    input  logic               bit_vld,
    input  logic               bit_in,
    input  logic [LIMIT_W-1:0] disc_limit,
    output logic               got_bit,
    output logic               got_null,
    output logic               fct_pulse,
    output logic               char_strobe,
    output logic               char_flag,
    output logic [DATA_W-1:0]  char_byte,
    output logic               tc_tick,
    output logic [1:0]         tc_ctrl,
    output logic [DATA_W-3:0]  tc_count,
    output logic               err_disc,
    output logic               err_par,
    output logic               err_esc
);

    logic              f_done;
    logic              f_ctrl;
    logic [DATA_W-1:0] f_payload;
    logic              f_par_err;

    sw_rx_disc #(
        .LIM_W(LIMIT_W)
    ) u_disc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .act      (line_act),
        .limit    (disc_limit),
        .got_bit  (got_bit),
        .err_disc (err_disc)
    );

    sw_rx_framer #(
        .DW(DATA_W),
        .CW(CTL_W)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (rx_en),
        .bit_vld      (bit_vld),
        .bit_in       (bit_in),
        .synced       (got_null),
        .done         (f_done),
        .done_ctrl    (f_ctrl),
        .done_payload (f_payload),
        .par_err      (f_par_err)
    );

    sw_rx_decode #(
        .DW(DATA_W)
    ) u_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (rx_en),
        .done         (f_done),
        .done_ctrl    (f_ctrl),
        .done_payload (f_payload),
        .par_err      (f_par_err),
        .fct_pulse    (fct_pulse),
        .char_strobe  (char_strobe),
        .char_flag    (char_flag),
        .char_byte    (char_byte),
        .tc_tick      (tc_tick),
        .tc_ctrl      (tc_ctrl),
        .tc_count     (tc_count),
        .err_par      (err_par),
        .err_esc      (err_esc)
    );

endmodule

// File: rtl/sw_char_rx_chk.sv
module sw_char_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       line_act,
    input logic       bit_vld,
    input logic       bit_in,
    input logic [7:0] disc_limit,
    input logic       got_bit,
    input logic       got_null,
    input logic       fct_pulse,
    input logic       char_strobe,
    input logic       char_flag,
    input logic [7:0] char_byte,
    input logic       tc_tick,
    input logic [1:0] tc_ctrl,
    input logic [5:0] tc_count,
    input logic       err_disc,
    input logic       err_par,
    input logic       err_esc
);

    assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({char_strobe, fct_pulse, tc_tick}));

    assert_end_marker_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (char_strobe && char_flag) |-> (char_byte[7:1] == 7'd0));

    assert_tc_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tc_tick && $past(rx_en)) |-> $stable({tc_ctrl, tc_count}));

    assert_par_after_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_par |-> got_null);

    assert_par_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par && rx_en) |=> err_par);

    assert_esc_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_esc && rx_en) |=> err_esc);

    assert_silent_after_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_par || err_esc) |=> !(char_strobe || fct_pulse || tc_tick));

    assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !(got_bit || got_null || err_par || err_esc || err_disc));

    assert_disc_needs_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_disc |-> got_bit);

    assert_activity_clears_disc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        line_act |=> !err_disc);

    assert_null_after_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (got_null && rx_en) |=> got_null);

endmodule

bind sw_char_rx sw_char_rx_chk u_chk (.*);

// File: tb/sw_char_rx_test.sv
`timescale 1ns/1ps
module sw_char_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       line_act = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] disc_limit = 8'd200;
    logic       got_bit, got_null, fct_pulse, char_strobe, char_flag;
    logic [7:0] char_byte;
    logic       tc_tick;
    logic [1:0] tc_ctrl;
    logic [5:0] tc_count;
    logic       err_disc, err_par, err_esc;

    int n_checks = 0;
    int n_errors = 0;
    int obs_events = 0;
    int exp_events = 0;

    logic       tx_acc = 1'b0;
    logic       m_esc = 1'b0;
    logic       m_block = 1'b0;
    logic       m_epar = 1'b0;
    logic       m_eesc = 1'b0;
    logic [1:0] m_tctl = '0;
    logic [5:0] m_tcnt = '0;

    always #4 clk = ~clk;

    sw_char_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .line_act(line_act),
        .bit_vld(bit_vld), .bit_in(bit_in), .disc_limit(disc_limit),
        .got_bit(got_bit), .got_null(got_null), .fct_pulse(fct_pulse),
        .char_strobe(char_strobe), .char_flag(char_flag), .char_byte(char_byte),
        .tc_tick(tc_tick), .tc_ctrl(tc_ctrl), .tc_count(tc_count),
        .err_disc(err_disc), .err_par(err_par), .err_esc(err_esc)
    );

    always @(negedge clk) begin
        if (char_strobe || fct_pulse || tc_tick) obs_events++;
    end

    function automatic logic [31:0] pack_obs();
        return {9'd0, char_strobe, char_flag, char_byte, fct_pulse, tc_tick,
                tc_ctrl, tc_count, err_par, err_esc, got_null};
    endfunction

    function automatic logic [31:0] pack_exp(input logic stb, input logic flg,
            input logic [7:0] byt, input logic fct, input logic tick);
        return {9'd0, stb, flg, byt, fct, tick, m_tctl, m_tcnt, m_epar, m_eesc, 1'b1};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b, input logic act);
        @(negedge clk);
        bit_vld = 1'b1; bit_in = b; line_act = act;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0; line_act = 1'b0;
            @(posedge clk);
        end
    endtask

    task automatic send_char(input logic ctrl, input logic [7:0] pay,
                             input logic bad, input int quiet);
        int   n;
        logic p;
        logic x;
        n = ctrl ? 2 : 8;
        p = 1'b1 ^ tx_acc ^ ctrl ^ bad;
        drive_bit(p, 1'b1);
        drive_bit(ctrl, (n + 1) >= quiet);
        x = 1'b0;
        for (int k = 0; k < n; k++) begin
            drive_bit(pay[k], (n - 1 - k) >= quiet);
            x = x ^ pay[k];
        end
        tx_acc = x;
    endtask

    task automatic model_clear();
        m_esc = 0; m_block = 0; m_epar = 0; m_eesc = 0; m_tctl = '0; m_tcnt = '0;
    endtask

    // send one character and compare the outputs of the following cycle with the model
    task automatic send_expect(input string req, input logic ctrl, input logic [7:0] pay,
                               input logic bad, input int quiet);
        logic stb, flg, fct, tick;
        logic [7:0] byt;
        send_char(ctrl, pay, bad, quiet);
        #2;
        stb = 0; flg = 0; fct = 0; tick = 0; byt = '0;
        if (bad) begin
            m_epar = 1; m_block = 1;
        end else if (!m_block) begin
            if (ctrl) begin
                if (m_esc) begin
                    m_esc = 0;
                    if (pay[1:0] != 2'd0) begin m_eesc = 1; m_block = 1; end
                end else if (pay[1:0] == 2'd0) fct = 1;
                else if (pay[1:0] == 2'd1) begin stb = 1; flg = 1; byt = 8'h00; end
                else if (pay[1:0] == 2'd2) begin stb = 1; flg = 1; byt = 8'h01; end
                else m_esc = 1;
            end else if (m_esc) begin
                m_esc = 0; tick = 1; m_tctl = pay[7:6]; m_tcnt = pay[5:0];
            end else begin
                stb = 1; byt = pay;
            end
        end
        if (stb || fct || tick) exp_events++;
        chk(req, pack_obs(), pack_exp(stb, flg, byt, fct, tick));
    endtask

    task automatic do_sync();
        for (int i = 0; i < 3; i++) drive_bit(1'b0, 1'b1);
        send_char(1'b1, 8'd3, 1'b0, 0);
        #2;
        chk("R3 no alignment mid-pattern", {31'd0, got_null}, 32'd0);
        send_char(1'b1, 8'd0, 1'b0, 0);
        #2;
        chk("R3 alignment on NULL, no pulse", pack_obs(), pack_exp(0, 0, 8'h00, 0, 0));
        tx_acc = 1'b0;
    endtask

    task automatic disable_pulse(input string req);
        @(negedge clk);
        rx_en = 1'b0; bit_vld = 1'b0; line_act = 1'b0;
        @(posedge clk);
        #2;
        chk(req, {9'd0, got_bit, got_null, err_disc, err_par, err_esc, tc_ctrl, tc_count,
                  char_strobe, fct_pulse, tc_tick}, 32'd0);
        model_clear();
        @(negedge clk);
        rx_en = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        int seed_init;
        int kind;
        logic [7:0] r;
        seed_init = $urandom(32'd2024);

        // R1: outputs idle while reset is held
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset outputs", {9'd0, got_bit, got_null, fct_pulse, char_strobe, char_flag,
             char_byte, tc_tick, tc_ctrl, tc_count, err_disc, err_par, err_esc}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; rx_en = 1'b1;
        @(posedge clk);
        #2;
        chk("R2 no bit before activity", {31'd0, got_bit}, 32'd0);
        drive_bit(1'b1, 1'b1);
        #2;
        chk("R2 got_bit after activity", {30'd0, got_bit, got_null}, 32'd2);

        // R3: junk, then alignment
        do_sync();

        // directed characters (R4, R5, R6)
        send_expect("R4 flow-control pulse", 1'b1, 8'd0, 1'b0, 0);
        send_expect("R4 escape of NULL", 1'b1, 8'd3, 1'b0, 0);
        send_expect("R4 NULL gives no pulse", 1'b1, 8'd0, 1'b0, 0);
        send_expect("R5 data byte", 1'b0, 8'hA5, 1'b0, 0);
        send_expect("R5 end of packet", 1'b1, 8'd1, 1'b0, 0);
        send_expect("R5 error end of packet", 1'b1, 8'd2, 1'b0, 0);
        send_expect("R5 data byte ff", 1'b0, 8'hFF, 1'b0, 0);
        send_expect("R6 escape of time code", 1'b1, 8'd3, 1'b0, 0);
        send_expect("R6 time code tick", 1'b0, 8'hC7, 1'b0, 0);
        send_expect("R6 time code held", 1'b0, 8'h00, 1'b0, 0);

        // constrained random character stream
        for (int i = 0; i < 300; i++) begin
            kind = $urandom % 8;
            r = 8'($urandom);
            case (kind)
                0, 1, 2: send_expect("R5 random data", 1'b0, r, 1'b0, 0);
                3: send_expect("R4 random flow-control", 1'b1, 8'd0, 1'b0, 0);
                4: send_expect("R5 random end of packet", 1'b1, 8'd1, 1'b0, 0);
                5: send_expect("R5 random error end", 1'b1, 8'd2, 1'b0, 0);
                6: begin
                    send_expect("R6 random escape", 1'b1, 8'd3, 1'b0, 0);
                    send_expect("R6 random time code", 1'b0, r, 1'b0, 0);
                end
                default: begin
                    send_expect("R4 random escape", 1'b1, 8'd3, 1'b0, 0);
                    send_expect("R4 random NULL", 1'b1, 8'd0, 1'b0, 0);
                end
            endcase
        end

        // R7, R9: parity error, then silence
        send_expect("R7 parity error flagged", 1'b0, 8'h3C, 1'b1, 0);
        send_expect("R9 data after parity error", 1'b0, 8'h12, 1'b0, 0);
        send_expect("R9 flow-control after parity error", 1'b1, 8'd0, 1'b0, 0);

        // R10: disable clears everything
        disable_pulse("R10 disable clears state");

        // R8, R9: escape followed by escape
        do_sync();
        send_expect("R8 first escape", 1'b1, 8'd3, 1'b0, 0);
        send_expect("R8 escape then escape", 1'b1, 8'd3, 1'b0, 0);
        send_expect("R9 data after escape error", 1'b0, 8'h55, 1'b0, 0);
        disable_pulse("R10 disable clears escape error");

        // R8: escape followed by end of packet
        do_sync();
        send_expect("R8 escape before eop", 1'b1, 8'd3, 1'b0, 0);
        send_expect("R8 escape then end of packet", 1'b1, 8'd1, 1'b0, 0);
        disable_pulse("R10 disable after escape error");

        // R11: disconnect timing
        disc_limit = 8'd5;
        drive_bit(1'b0, 1'b1);
        idle(4);
        #2;
        chk("R11 no disconnect before limit", {31'd0, err_disc}, 32'd0);
        idle(1);
        #2;
        chk("R11 disconnect at limit", {31'd0, err_disc}, 32'd1);
        drive_bit(1'b0, 1'b1);
        #2;
        chk("R11 activity clears disconnect", {31'd0, err_disc}, 32'd0);
        disc_limit = 8'd0;
        idle(1);
        #2;
        chk("R11 limit zero acts as one", {31'd0, err_disc}, 32'd1);
        disable_pulse("R10 disable clears disconnect");

        // R6 with R11 on the same edge
        disc_limit = 8'd200;
        do_sync();
        disc_limit = 8'd3;
        send_expect("R6 escape before quiet tail", 1'b1, 8'd3, 1'b0, 0);
        send_expect("R6 time code with quiet tail", 1'b0, 8'h9E, 1'b0, 3);
        chk("R11 disconnect with time code", {31'd0, err_disc}, 32'd1);

        idle(2);
        #2;
        chk("R5 no extra events", 32'(obs_events), 32'(exp_events));

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule